// File: doc/BRIEF.md
# SPI Primary Frame Engine

This block is the controller side of a full-duplex serial-peripheral link on single data lines. Each frame moves one word of programmable width, 4 to 16 bits, out on the serial output and in from the serial input at the same time, most significant bit first. The serial clock comes from the input clock through an even divider. Its idle level and its capture edge follow the clock polarity and phase settings, so all four modes are supported. A mask picks which of four active-low chip selects go low for the frame.

Words to send arrive on a valid/ready handshake. Each received word leaves on a one-cycle valid pulse. The received bit can be sampled a programmable number of input-clock cycles after its nominal capture edge, to absorb round-trip delay at high serial rates. With continuous mode set and a next word waiting at the end of a frame, the chip select stays low and the clock runs on with no gap.

Top module: `spi_frame_master`

## Requirements
- R1: The effective frame length n is len_i clamped to 4..16. The word to send is tx_data_i[n-1:0] and goes out most significant bit first. Bits of tx_data_i above n-1 are never sent.
- R2: The serial clock half period is div_i[15:1] input-clock cycles, so bit 0 of div_i is ignored. When div_i[15:1] is 0, tx_ready_o stays low and no frame starts.
- R3: While no frame is active, sclk_o rests at the level of cpol_i. Each frame ends with sclk_o back at that level.
- R4: The capture edge is the first edge of each bit when cpha_i is 0, and the second edge when cpha_i is 1. mosi_o changes only on the other edges. With cpha_i at 0, the first bit is on mosi_o as soon as the chip select goes low.
- R5: Each line of cs_n_o whose bit in cs_en_i is 1 goes low for the frame, and the other lines stay high. The first clock edge comes one half period after chip-select assertion. Edges then follow every half period, 2n of them per frame. The chip select releases one half period after the last edge.
- R6: If cont_i is high and a new word is valid at the last edge of a frame, that word is taken there. The chip select stays low and the edge spacing stays one half period across the frame boundary.
- R7: The serial input is sampled rx_dly_i (0..7) input-clock cycles after each capture edge. A new frame does not start while any such delayed sample is still pending.
- R8: busy_o is high exactly while the frame's chip selects are asserted.
- R9: After the n-th sample of a frame, rx_valid_o is high for one cycle. At the same time rx_data_o holds the received word in bits n-1:0, with zeros above.
- R10: After reset all chip selects are high, busy_o and rx_valid_o are low, and sclk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase: 0 captures on the first edge of each bit |
| cont_i | input | 1 | Continuous mode: chain frames without releasing chip select |
| div_i | input | 16 | Clock divider, even values, below 2 means clock off |
| len_i | input | 5 | Frame length in bits, clamped to 4..16 |
| cs_en_i | input | 4 | Chip-select enable mask |
| rx_dly_i | input | 3 | Receive sample delay in input-clock cycles |
| tx_data_i | input | 16 | Word to send, right aligned |
| tx_valid_i | input | 1 | Word to send is valid |
| tx_ready_o | output | 1 | Engine takes the word this cycle if valid |
| rx_data_o | output | 16 | Received word, right aligned |
| rx_valid_o | output | 1 | One-cycle pulse: received word present |
| busy_o | output | 1 | Frame active |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 4 | Chip selects, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
On every cycle the assertions check four things. The idle clock level follows cpol_i. Chip selects are released whenever the engine is idle and stay unchanged inside a frame. No word is accepted while the divider is below 2. The received-word strobe lasts a single cycle. Bit order, capture edges, edge spacing, the effect of the sample delay and seamless chaining in continuous mode depend on the data exchanged. A bench slave model shows these: it answers on capture edges through a delay line that matches rx_dly_i. The bench sweeps the four modes against several lengths, dividers (odd values included) and delays.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fm_state_e;
endpackage

// File: rtl/spi_fm_half_tick.sv
module spi_fm_half_tick #(
  parameter int HALF_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/spi_fm_tx_shift.sv
module spi_fm_tx_shift #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cpha_i,
  input  logic [LEN_W-1:0]  n_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              chg_i,
  output logic              mosi_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] aligned;
  logic [LEN_W-1:0]  amt;

  assign amt     = LEN_W'(DATA_W) - n_i;
  assign aligned = word_i << amt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      mosi_o <= 1'b0;
    end else if (load_i) begin
      if (!cpha_i) begin
        // phase 0: first bit must be on the line before the first edge
        mosi_o <= aligned[DATA_W-1];
        sh_q   <= {aligned[DATA_W-2:0], 1'b0};
      end else begin
        sh_q   <= aligned;
      end
    end else if (chg_i) begin
      mosi_o <= sh_q[DATA_W-1];
      sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_fm_rx_capture.sv
module spi_fm_rx_capture #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int DLY_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [LEN_W-1:0]  n_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              pend_o
);
  localparam int DEPTH = 2 ** DLY_W;

  logic [DEPTH-2:0]  pipe_q;
  logic [DATA_W-2:0] sh_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              take;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] keep;
  logic [LEN_W-1:0]  amt;

  // delayed strobes travel independently, so overlapping captures are fine
  assign take   = (dly_i == '0) ? cap_i : pipe_q[dly_i - DLY_W'(1)];
  assign pend_o = |pipe_q;
  assign nxt    = {sh_q, miso_i};
  assign amt    = LEN_W'(DATA_W) - n_i;
  assign keep   = {DATA_W{1'b1}} >> amt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q     <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      pipe_q     <= {pipe_q[DEPTH-3:0], cap_i};
      rx_valid_o <= 1'b0;
      if (take) begin
        sh_q <= nxt[DATA_W-2:0];
        if (cnt_q == n_i - LEN_W'(1)) begin
          cnt_q      <= '0;
          rx_data_o  <= nxt & keep;
          rx_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CS_W    = 4,
  parameter int DIV_W   = 16,
  parameter int DLY_W   = 3,
  parameter int MIN_LEN = 4,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              cont_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CS_W-1:0]   cs_en_i,
  input  logic [DLY_W-1:0]  rx_dly_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int HALF_W = DIV_W - 1;
  localparam int EDGE_W = LEN_W + 1;

  fm_state_e         state_q;
  logic [HALF_W-1:0] half_q;
  logic              cpol_q, cpha_q;
  logic [CS_W-1:0]   cs_en_q;
  logic [LEN_W-1:0]  n_q, n_live;
  logic [DLY_W-1:0]  dly_q;
  logic [EDGE_W-1:0] ecnt_q, last_e;
  logic              tgl_q;
  logic [HALF_W-1:0] half_live;
  logic              unused_div0;
  logic              tick, rx_pend, idle, start, reload;
  logic              in_frame, edge_ev, cap_ev, chg_ev, at_last, end_ev;
  logic              load_cpha;
  logic [LEN_W-1:0]  load_n;

  assign half_live   = div_i[DIV_W-1:1];
  assign unused_div0 = div_i[0];

  always_comb begin
    if (len_i < LEN_W'(MIN_LEN))     n_live = LEN_W'(MIN_LEN);
    else if (len_i > LEN_W'(DATA_W)) n_live = LEN_W'(DATA_W);
    else                             n_live = len_i;
  end

  assign idle     = (state_q == ST_IDLE);
  assign last_e   = {n_q, 1'b0};
  assign in_frame = (ecnt_q != last_e);
  assign edge_ev  = tick && in_frame;
  assign end_ev   = tick && !in_frame;
  assign at_last  = tick && (ecnt_q == last_e - EDGE_W'(1));
  assign cap_ev   = edge_ev && (ecnt_q[0] == cpha_q);
  assign chg_ev   = edge_ev && (ecnt_q[0] != cpha_q) && !(!cpha_q && at_last);

  assign tx_ready_o = idle ? ((|half_live) && !rx_pend) : (at_last && cont_i);
  assign start      = idle && tx_ready_o && tx_valid_i;
  assign reload     = at_last && cont_i && tx_valid_i;
  assign load_cpha  = idle ? cpha_i : cpha_q;
  assign load_n     = idle ? n_live : n_q;

  assign busy_o = !idle;
  assign sclk_o = cpol_q ^ tgl_q;
  assign cs_n_o = ~(cs_en_q & {CS_W{busy_o}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      cs_en_q <= '0;
      n_q     <= LEN_W'(MIN_LEN);
      dly_q   <= '0;
      ecnt_q  <= '0;
      tgl_q   <= 1'b0;
    end else if (idle) begin
      cpol_q <= cpol_i;
      if (start) begin
        state_q <= ST_RUN;
        half_q  <= half_live;
        cpha_q  <= cpha_i;
        cs_en_q <= cs_en_i;
        n_q     <= n_live;
        dly_q   <= rx_dly_i;
        ecnt_q  <= '0;
        tgl_q   <= 1'b0;
      end
    end else begin
      if (edge_ev) begin
        tgl_q  <= ~tgl_q;
        ecnt_q <= reload ? '0 : ecnt_q + EDGE_W'(1);
      end
      if (end_ev) state_q <= ST_IDLE;
    end
  end

  spi_fm_half_tick #(.HALF_W(HALF_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .half_i (half_q),
    .tick_o (tick)
  );

  spi_fm_tx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start || reload),
    .cpha_i (load_cpha),
    .n_i    (load_n),
    .word_i (tx_data_i),
    .chg_i  (chg_ev),
    .mosi_o (mosi_o)
  );

  spi_fm_rx_capture #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DLY_W(DLY_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_ev),
    .dly_i      (dly_q),
    .n_i        (n_q),
    .miso_i     (miso_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .pend_o     (rx_pend)
  );
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk #(
  parameter int CS_W   = 4,
  parameter int HALF_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpol_i,
  input logic [HALF_W-1:0] half_i,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic              busy_o,
  input logic              sclk_o,
  input logic [CS_W-1:0]   cs_n_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !busy_o && !$past(busy_o)) |-> (sclk_o == $past(cpol_i)));

  assert_end_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $fell(busy_o)) |-> $stable(sclk_o));

  assert_cs_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_n_o == {CS_W{1'b1}}));

  assert_cs_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && busy_o && $past(busy_o)) |-> $stable(cs_n_o));

  assert_clock_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && half_i == '0) |-> !tx_ready_o);

  assert_rx_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind spi_frame_master spi_frame_master_chk #(.CS_W(CS_W), .HALF_W(DIV_W - 1)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpol_i     (cpol_i),
  .half_i     (div_i[DIV_W-1:1]),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .busy_o     (busy_o),
  .sclk_o     (sclk_o),
  .cs_n_o     (cs_n_o)
);

// File: tb/spi_frame_master_tb_top.sv
`timescale 1ns/1ps
module spi_frame_master_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpol_i = 1'b0, cpha_i = 1'b0, cont_i = 1'b0;
  logic [15:0] div_i = 16'd4;
  logic [4:0]  len_i = 5'd8;
  logic [3:0]  cs_en_i = 4'b0001;
  logic [2:0]  rx_dly_i = 3'd0;
  logic [15:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [15:0] rx_data_o;
  logic        rx_valid_o, busy_o, sclk_o, mosi_o;
  logic [3:0]  cs_n_o;
  logic        miso_i = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_frame_master dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(cpol_i), .cpha_i(cpha_i), .cont_i(cont_i),
    .div_i(div_i), .len_i(len_i), .cs_en_i(cs_en_i), .rx_dly_i(rx_dly_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .busy_o(busy_o), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave model and monitor state
  int          cyc = 0, last_t = 0, edges = 0, k = 0, mf = 0, rf = 0, opens = 0;
  int          cur_n = 8, cur_h = 2, cur_d = 0;
  logic        cur_cpol = 1'b0, cur_cpha = 1'b0;
  logic [3:0]  exp_mask = 4'b0001;
  logic [15:0] tw [16];
  logic [15:0] sw [16];
  logic [15:0] mosi_rec [16];
  logic [15:0] rx_rec [16];
  logic [15:0] mw = '0;
  logic [7:0]  hist = '0;
  logic        prev_cs = 1'b0, prev_sclk = 1'b0, prev_rxv = 1'b0, ideal;
  bit          mon_on = 1'b0;
  bit          bad_t, bad_lvl, bad_cs, bad_busy = 1'b0, bad_pulse = 1'b0;

  function automatic logic [15:0] lmask(input int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  function automatic int clamp_len(input int l);
    return (l < 4) ? 4 : ((l > 16) ? 16 : l);
  endfunction

  always @(negedge clk_i) begin
    logic cs_act;
    cyc++;
    cs_act = (cs_n_o != 4'hF);
    if (mon_on) begin
      if (busy_o != cs_act) bad_busy = 1'b1;
      if (rx_valid_o && prev_rxv) bad_pulse = 1'b1;
      if (cs_act && !prev_cs) begin
        opens++;
        last_t = cyc;
        if (sclk_o != cur_cpol) bad_lvl = 1'b1;
        if (cs_n_o != ~exp_mask) bad_cs = 1'b1;
      end else if (cs_act) begin
        if (cs_n_o != ~exp_mask) bad_cs = 1'b1;
        if (sclk_o != prev_sclk) begin
          if (cyc - last_t != cur_h) bad_t = 1'b1;
          last_t = cyc;
          edges++;
          if (sclk_o == !(cur_cpol ^ cur_cpha)) begin
            mw = {mw[14:0], mosi_o};
            k++;
            if (k == cur_n) begin
              if (mf < 16) mosi_rec[mf] = mw & lmask(cur_n);
              mf++;
              k = 0;
            end
          end
        end
      end else if (prev_cs) begin
        if (cyc - last_t != cur_h) bad_t = 1'b1;
        if (sclk_o != cur_cpol) bad_lvl = 1'b1;
      end
      if (rx_valid_o) begin
        if (rf < 16) rx_rec[rf] = rx_data_o;
        rf++;
      end
    end
    ideal = (mf < 16 && k < cur_n) ? sw[mf][cur_n-1-k] : 1'b0;
    hist = {hist[6:0], ideal};
    miso_i = hist[cur_d];
    prev_cs = cs_act;
    prev_sclk = sclk_o;
    prev_rxv = rx_valid_o;
  end

  task automatic run(input int mode, input int len, input int div, input int dly,
                     input logic [3:0] mask, input int nfr, input int seed);
    cur_cpol = mode[1];
    cur_cpha = mode[0];
    cur_n = clamp_len(len);
    cur_h = div / 2;
    cur_d = dly;
    exp_mask = mask;
    for (int i = 0; i < 16; i++) begin
      tw[i] = 16'hA5C3 ^ 16'((seed + i) * 16'h3B1D);
      sw[i] = 16'h5E29 + 16'((seed + i) * 16'h1337);
    end
    mf = 0; rf = 0; k = 0; edges = 0; opens = 0;
    bad_t = 1'b0; bad_lvl = 1'b0; bad_cs = 1'b0;
    cpol_i = mode[1]; cpha_i = mode[0]; len_i = 5'(len); div_i = 16'(div);
    rx_dly_i = 3'(dly); cs_en_i = mask; cont_i = (nfr > 1);
    @(negedge clk_i);
    for (int i = 0; i < nfr; i++) begin
      tx_data_i = tw[i];
      tx_valid_i = 1'b1;
      while (!tx_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    tx_valid_i = 1'b0;
    while (rf < nfr || busy_o || cs_n_o != 4'hF) @(negedge clk_i);
    cont_i = 1'b0;
    repeat (10) @(negedge clk_i);
    for (int i = 0; i < nfr; i++) begin
      chk(mosi_rec[i] == (tw[i] & lmask(cur_n)), "R1/R4 sent word MSB first",
          32'(mosi_rec[i]), 32'(tw[i] & lmask(cur_n)));
      chk(rx_rec[i] == (sw[i] & lmask(cur_n)), "R7/R9 received word",
          32'(rx_rec[i]), 32'(sw[i] & lmask(cur_n)));
    end
    chk(rf == nfr, "R9 receive strobe count", 32'(rf), 32'(nfr));
    chk(edges == 2 * cur_n * nfr, "R5 edge count", 32'(edges), 32'(2 * cur_n * nfr));
    chk(!bad_t, "R2/R5/R6 edge spacing", 32'(bad_t), 32'd0);
    chk(!bad_lvl, "R3 idle and end level", 32'(bad_lvl), 32'd0);
    chk(!bad_cs, "R5 chip-select mask", 32'(bad_cs), 32'd0);
    chk(opens == 1, "R6 one chip-select window", 32'(opens), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(cs_n_o == 4'hF, "R10 cs after reset", 32'(cs_n_o), 32'hF);
    chk(!busy_o, "R10 busy after reset", 32'(busy_o), 32'd0);
    chk(!rx_valid_o, "R10 rx_valid after reset", 32'(rx_valid_o), 32'd0);
    chk(!sclk_o, "R10 sclk after reset", 32'(sclk_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    mon_on = 1'b1;

    // R2 divider below 2 turns the clock off
    for (int dv = 0; dv < 2; dv++) begin
      bit seen = 1'b0;
      div_i = 16'(dv);
      tx_data_i = 16'h1234;
      tx_valid_i = 1'b1;
      repeat (30) begin
        @(negedge clk_i);
        if (tx_ready_o || busy_o || cs_n_o != 4'hF) seen = 1'b1;
      end
      tx_valid_i = 1'b0;
      chk(!seen, "R2 divider below 2 starts nothing", 32'(seen), 32'd0);
    end

    // R1 length clamp at both ends
    run(2, 0, 4, 1, 4'b0100, 1, 7);
    run(1, 31, 2, 0, 4'b1000, 1, 9);

    // sweep: modes, lengths, dividers (odd ones act as next lower even), delays
    begin
      int idx = 0;
      for (int m = 0; m < 4; m++)
        for (int li = 0; li < 3; li++)
          for (int di = 0; di < 4; di++)
            for (int yi = 0; yi < 3; yi++) begin
              int len, div, dly;
              len = (li == 0) ? 4 : ((li == 1) ? 9 : 16);
              div = (di == 0) ? 2 : ((di == 1) ? 3 : ((di == 2) ? 6 : 7));
              dly = (yi == 0) ? 0 : ((yi == 1) ? 3 : 7);
              run(m, len, div, dly, 4'(1 << (idx % 4)) | 4'(idx % 3 == 0 ? 4'b1010 : 4'b0000),
                  1, idx);
              idx++;
            end
    end

    // R6 continuous frames
    run(0, 5, 2, 7, 4'b0011, 4, 101);
    run(3, 12, 4, 2, 4'b1111, 3, 202);
    run(1, 8, 5, 5, 4'b0010, 4, 303);

    chk(!bad_busy, "R8 busy matches chip-select window", 32'(bad_busy), 32'd0);
    chk(!bad_pulse, "R9 single-cycle strobe", 32'(bad_pulse), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule